// File: doc/BRIEF.md
# Reversible Decade Counter with Preset

A synchronous counter that steps through the decimal digits 0 to 9 in either direction. A single select input picks the direction. Each enabled clock edge moves the count one step. Counting up wraps from 9 to 0, and counting down wraps from 0 to 9. A preset input copies a 4-bit value into the count on the next edge, and it overrides counting. A four-bit code from 10 to 15 is outside the decimal range. If one is preset, the next enabled count brings the counter back into range.

Two outputs report the end of the range. The level flag is high when the count sits at the last digit for the current direction: 9 going up, 0 going down. The active-low ripple output repeats that flag during the low half of the clock, but only while counting is enabled. Cascaded stages can use it as a clock or as an enable for the next digit.

Top module: `dcnt_updown`

## Requirements
- R1: When rst_n is low at a rising clock edge, q becomes 0 after that edge.
- R2: When load_n is low at a rising edge, q takes the value of din after that edge, whatever cnt_en_n and dir_down are.
- R3: When load_n and cnt_en_n are both high at a rising edge, q keeps its value, and changes on din have no effect.
- R4: With cnt_en_n low and dir_down = 0, q increases by 1 on each edge, and 9 is followed by 0.
- R5: With cnt_en_n low and dir_down = 1, q decreases by 1 on each edge, and 0 is followed by 9.
- R6: If q holds a code from 10 to 15, the next enabled edge sets q to 0 when dir_down = 0, or to 9 when dir_down = 1.
- R7: term_flag is 1 exactly when dir_down = 0 and q = 9, or when dir_down = 1 and q = 0. It is 0 for codes 10 to 15. It follows dir_down without waiting for a clock edge.
- R8: ripple_n is 0 only while clk is low, term_flag is 1 and cnt_en_n is 0. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counting happens on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| load_n | input | 1 | Synchronous preset, active low |
| din | input | 4 | Preset value |
| q | output | 4 | Current count |
| term_flag | output | 1 | High at the last digit for the current direction |
| ripple_n | output | 1 | Active-low terminal pulse, present during the low clock phase |

## Verification
The bench targets both wrap points:
- A design that saturates would stick at 9 or 0.
- A design that wraps at the binary limit would show 10 after 9, or 15 after 0.

It presets codes 10 to 15 and confirms that one enabled edge brings the counter back to 0 or 9. A decoder that handled only legal codes would wander through the illegal values, or raise the terminal flag there.

The ripple output is checked in both clock phases and with counting disabled. A version that ignored the clock phase or the enable would give a low pulse in the wrong place.

A preset applied while counting is enabled is also checked. If counting took priority, the count would step instead of taking the preset value.

// File: rtl/dcnt_pkg.sv
// Package: shared types for the reversible decade counter.
// Assumes: the direction select is a single bit, where 1 means count down.
package dcnt_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/dcnt_step.sv
// Module: dcnt_step
// Computes the count one step ahead in the selected direction.
// Any code above the top digit is folded back: to 0 going up,
// and to the top digit going down.
// Assumes: MODULUS >= 2 and MODULUS <= 2**W.
module dcnt_step
    import dcnt_pkg::*;
#(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = $clog2(MODULUS)
) (
    input  logic [W-1:0] cur,
    input  dir_e         dir,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP  = W'(MODULUS - 1);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    // Next value: wrap at both ends and fold out-of-range codes.
    always_comb begin
        if (dir == DIR_UP) begin
            if (cur >= TOP) nxt = ZERO;
            else            nxt = cur + ONE;
        end else begin
            if (cur == ZERO || cur > TOP) nxt = TOP;
            else                          nxt = cur - ONE;
        end
    end
endmodule

// File: rtl/dcnt_state.sv
// Module: dcnt_state
// Holds the count register. Priority is reset, then preset, then count;
// with none of them active the register holds.
// Assumes: reset and preset are both synchronous and active low.
module dcnt_state
    import dcnt_pkg::*;
#(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en_n,
    input  logic         load_n,
    input  dir_e         dir,
    input  logic [W-1:0] din,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    // Count register with reset, preset and enable priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (!load_n)   q <= din;
        else if (!cnt_en_n) q <= nxt;
    end

    // R2: preset wins over counting
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (q == $past(din)));

    // R3: hold when neither preset nor count is active
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_n) |=> $stable(q));

    // R4: up step inside the range
    p_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && dir == DIR_UP && q < TOP)
        |=> (q == $past(q) + W'(1)));

    // R5: down step inside the range
    p_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && dir == DIR_DOWN && q != '0 && q <= TOP)
        |=> (q == $past(q) - W'(1)));

    // R6: out-of-range codes recover in one enabled step
    p_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && q > TOP)
        |=> (q == '0 || q == TOP));
endmodule

// File: rtl/dcnt_term.sv
// Module: dcnt_term
// Decodes the last digit for the current direction. Drives the level
// flag, and the ripple output that is active low during the low clock phase.
// Assumes: clk is a clean square wave; the ripple output is combinational.
module dcnt_term
    import dcnt_pkg::*;
#(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en_n,
    input  dir_e         dir,
    input  logic [W-1:0] q,
    output logic         term_flag,
    output logic         ripple_n
);
    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    // Last-digit decode: top digit going up, zero going down.
    always_comb begin
        if (dir == DIR_UP) term_flag = (q == TOP);
        else               term_flag = (q == '0);
    end

    // Ripple pulse: low only in the low clock phase when enabled at the end.
    always_comb begin
        ripple_n = ~(term_flag & ~cnt_en_n & ~clk);
    end

    // R7: the flag never rises on a code other than the end digit
    p_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
        term_flag |-> ((dir == DIR_UP) ? (q == TOP) : (q == '0)));

    // R7: the flag is never raised for an out-of-range code
    p_term_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q > TOP) |-> !term_flag);
endmodule

// File: rtl/dcnt_updown.sv
// Module: dcnt_updown
// Top of the reversible decade counter. Connects the step logic, the
// count register and the end-of-range decode.
// Assumes: one clock domain; every control input is sampled on the rising edge.
module dcnt_updown
    import dcnt_pkg::*;
#(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en_n,
    input  logic         dir_down,
    input  logic         load_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         term_flag,
    output logic         ripple_n
);
    dir_e         dir;
    logic [W-1:0] nxt;
    logic [W-1:0] q_int;

    // Direction decode from the raw select bit.
    always_comb begin
        dir = dir_down ? DIR_DOWN : DIR_UP;
    end

    dcnt_step #(.MODULUS(MODULUS), .W(W)) u_step (
        .cur (q_int),
        .dir (dir),
        .nxt (nxt)
    );

    dcnt_state #(.MODULUS(MODULUS), .W(W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en_n (cnt_en_n),
        .load_n   (load_n),
        .dir      (dir),
        .din      (din),
        .nxt      (nxt),
        .q        (q_int)
    );

    dcnt_term #(.MODULUS(MODULUS), .W(W)) u_term (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en_n  (cnt_en_n),
        .dir       (dir),
        .q         (q_int),
        .term_flag (term_flag),
        .ripple_n  (ripple_n)
    );

    // Output copy of the count register.
    always_comb begin
        q = q_int;
    end
endmodule

// File: tb/dcnt_updown_tb.sv
module dcnt_updown_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en_n = 1'b1;
    logic       dir_down = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] din = 4'd0;
    logic [3:0] q;
    logic       term_flag;
    logic       ripple_n;

    int n_checks = 0;
    int n_errors = 0;

    dcnt_updown u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .dir_down(dir_down),
        .load_n(load_n), .din(din), .q(q), .term_flag(term_flag),
        .ripple_n(ripple_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One edge: outputs are read in the low phase that follows it.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic preset(input int v);
        load_n = 1'b0; din = 4'(v);
        tick();
        load_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; load_n = 1'b1; cnt_en_n = 1'b0; dir_down = 1'b0;
        tick(); tick();
        chk("R1 q after reset", q, 0);
        chk("R7 flag at 0 going up", term_flag, 0);
        dir_down = 1'b1; #1;
        chk("R7 flag at 0 going down", term_flag, 1);
        rst_n = 1'b1; cnt_en_n = 1'b1; dir_down = 1'b0;
    endtask

    task automatic t_up();
        int e;
        preset(0);
        chk("R2 preset 0", q, 0);
        dir_down = 1'b0; cnt_en_n = 1'b0;
        e = 0;
        for (int i = 0; i < 13; i++) begin
            tick();
            e = (e + 1) % 10;
            chk("R4 up step", q, e);
            chk("R7 flag going up", term_flag, (e == 9) ? 1 : 0);
        end
        cnt_en_n = 1'b1;
    endtask

    task automatic t_down();
        int e;
        preset(3);
        dir_down = 1'b1; cnt_en_n = 1'b0;
        e = 3;
        for (int i = 0; i < 12; i++) begin
            tick();
            e = (e == 0) ? 9 : e - 1;
            chk("R5 down step", q, e);
            chk("R7 flag going down", term_flag, (e == 0) ? 1 : 0);
        end
        cnt_en_n = 1'b1;
    endtask

    task automatic t_hold();
        preset(6);
        cnt_en_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            din = 4'(i + 1);
            tick();
            chk("R3 hold ignores din", q, 6);
        end
    endtask

    task automatic t_load_priority();
        preset(4);
        cnt_en_n = 1'b0; dir_down = 1'b0;
        load_n = 1'b0; din = 4'd7;
        tick();
        chk("R2 preset over count", q, 7);
        dir_down = 1'b1; din = 4'd2;
        tick();
        chk("R2 preset over down count", q, 2);
        load_n = 1'b1; cnt_en_n = 1'b1;
    endtask

    task automatic t_illegal();
        for (int v = 10; v < 16; v++) begin
            preset(v);
            dir_down = 1'b0; #1;
            chk("R7 no flag on illegal up", term_flag, 0);
            dir_down = 1'b1; #1;
            chk("R7 no flag on illegal down", term_flag, 0);
            dir_down = (v % 2 == 1); cnt_en_n = 1'b0;
            tick();
            chk("R6 recovery", q, (v % 2 == 1) ? 9 : 0);
            cnt_en_n = 1'b1;
        end
    endtask

    task automatic t_ripple();
        preset(9);
        dir_down = 1'b0; cnt_en_n = 1'b0;
        load_n = 1'b0; din = 4'd9; #1;
        chk("R8 ripple low in low phase", ripple_n, 0);
        @(posedge clk); #1;
        chk("R8 ripple high in high phase", ripple_n, 1);
        chk("R7 flag level in high phase", term_flag, 1);
        @(negedge clk); #1;
        chk("R8 ripple low again", ripple_n, 0);
        cnt_en_n = 1'b1; #1;
        chk("R8 ripple high when disabled", ripple_n, 1);
        cnt_en_n = 1'b0; dir_down = 1'b1; #1;
        chk("R8 ripple high after direction flip", ripple_n, 1);
        load_n = 1'b1; cnt_en_n = 1'b1; dir_down = 1'b0;
    endtask

    initial begin
        #1;
        t_reset();
        t_up();
        t_down();
        t_hold();
        t_load_priority();
        t_illegal();
        t_ripple();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule